// File: doc/BRIEF.md
# Windowed-Configuration GPIO Port

This block is an 8-pin general-purpose I/O port that sits on a small processor bus. Software reaches it through four byte registers chosen by a two-bit register select: a pointer register, a configuration window, a read-only input data register and an output data register. The configuration window does not hold a value of its own. Every access to it lands in whichever configuration subregister the pointer currently names, so one bus location reaches several configuration stores.

Two subregisters are implemented. Pointer value 01h reaches the per-pin direction store, and pointer value 02h reaches the per-pin alternate-function enable store. Every other pointer value names nothing: a read through the window returns 00h and a write is dropped. Each pin drives its output data bit when its direction bit is 0 and is left undriven when the bit is 1. When a pin's alternate-function enable is set, the peripheral-side enable and data inputs take the pin over and the direction bit is ignored. Pin levels go through a two-stage synchronizer and are then captured into the input data register on every clock.

The reset input is asynchronous and active low. The block releases its registers two clock edges after the reset input rises.

Top module: `wgp_port`

## Requirements
- R1: After reset, the pointer register, the output data register and the input data register read 00h, the window reads 00h, and no pin is driven (`pin_oe` = 00h).
- R2: A read or write through the window (`bus_sel` = 1) reaches the subregister the pointer selects: 01h is the direction store and 02h is the alternate-function enable store. Read data is combinational from the selected register.
- R3: Direction bit n belongs to pin n. All eight bits can be read and written, and they reset to 1 (FFh).
- R4: With alternate function off and direction bit 0, the pin is driven (`pin_oe` bit 1) with the output data register bit on `pin_o`.
- R5: With alternate function off and direction bit 1, the pin is undriven (`pin_oe` bit 0) and its `pin_o` bit is 0.
- R6: With the alternate-function enable bit set, `pin_oe` follows `alt_oe` and `pin_o` equals `alt_o` AND `alt_oe` for that pin, whatever the direction bit holds.
- R7: The input data register (`bus_sel` = 2) shows a change on `pin_i` after the third rising clock edge following that change, and not after the second.
- R8: A write with `bus_sel` = 2 has no effect. The input data register keeps showing the sampled pin levels.
- R9: For a pointer value other than 01h or 02h, a window read returns 00h and a window write leaves both subregisters unchanged.
- R10: The pointer register (`bus_sel` = 0) and the output data register (`bus_sel` = 3) take the write data on the clock edge where `bus_we` is high, and read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Register select: 0 pointer, 1 window, 2 input data, 3 output data |
| bus_we | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data from the selected register |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output data |
| pin_oe | output | 8 | Pad output enable, 1 = drive |
| alt_o | input | 8 | Alternate-function output data |
| alt_oe | input | 8 | Alternate-function output enable |

## Verification
A wrong pointer value makes window writes land in the wrong store. This shows at the pins on the next cycle, when `pin_oe` no longer matches the written direction, and on an immediate read through the window. A direction or enable bit that has been corrupted changes `pin_oe` and `pin_o` combinationally, in the same cycle the bit goes wrong. A synchronizer stage too many or too few moves the visible input change by one edge, which the check at edges two and three catches. A write that leaks into an unimplemented subregister only shows when the pointer is moved back to 01h or 02h, so the bench re-reads both stores after such a write.

// File: rtl/wgp_pkg.sv
package wgp_pkg;
  typedef enum logic [1:0] {
    RS_PTR = 2'd0,
    RS_WIN = 2'd1,
    RS_IN  = 2'd2,
    RS_OUT = 2'd3
  } regsel_e;

  localparam int SUB_DIR = 1;
  localparam int SUB_ALT = 2;
endpackage

// File: rtl/wgp_sync.sv
module wgp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stg_d;
      if (s == 0) begin : g_first
        always_comb stg_d = d;
      end else begin : g_rest
        always_comb stg_d = stg_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_d;
      end
    end
  endgenerate

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/wgp_regs.sv
module wgp_regs
  import wgp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  regsel_e       sel,
  input  logic          we,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] dir_q,
  output logic [DW-1:0] alt_q,
  output logic [DW-1:0] out_q
);
  localparam logic [DW-1:0] PTR_DIR = DW'(SUB_DIR);
  localparam logic [DW-1:0] PTR_ALT = DW'(SUB_ALT);

  logic [DW-1:0] ptr_q;
  logic          ptr_en, dir_en, alt_en, out_en;
  logic          hit_dir, hit_alt;
  logic [DW-1:0] win_rd;

  always_comb begin
    hit_dir = (ptr_q == PTR_DIR);
    hit_alt = (ptr_q == PTR_ALT);
    ptr_en  = we && (sel == RS_PTR);
    out_en  = we && (sel == RS_OUT);
    dir_en  = we && (sel == RS_WIN) && hit_dir;
    alt_en  = we && (sel == RS_WIN) && hit_alt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      dir_q <= '1;
      alt_q <= '0;
      out_q <= '0;
    end else begin
      if (ptr_en) ptr_q <= wdata;
      if (dir_en) dir_q <= wdata;
      if (alt_en) alt_q <= wdata;
      if (out_en) out_q <= wdata;
    end
  end

  always_comb begin
    if (hit_dir)      win_rd = dir_q;
    else if (hit_alt) win_rd = alt_q;
    else              win_rd = '0;
  end

  always_comb begin
    unique case (sel)
      RS_PTR:  rdata = ptr_q;
      RS_WIN:  rdata = win_rd;
      RS_IN:   rdata = in_data;
      RS_OUT:  rdata = out_q;
      default: rdata = '0;
    endcase
  end

  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == RS_WIN && ptr_q == PTR_DIR) |=> (dir_q == $past(wdata)));

  // R9
  unimpl_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == RS_WIN && ptr_q != PTR_DIR && ptr_q != PTR_ALT)
      |=> ($stable(dir_q) && $stable(alt_q)));

  // R8
  in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && sel == RS_IN) |=> ($stable(dir_q) && $stable(alt_q) && $stable(out_q) && $stable(ptr_q)));
endmodule

// File: rtl/wgp_pinmux.sv
module wgp_pinmux #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] dir,
  input  logic [DW-1:0] alt_en,
  input  logic [DW-1:0] out_data,
  input  logic [DW-1:0] alt_o,
  input  logic [DW-1:0] alt_oe,
  output logic [DW-1:0] pin_o,
  output logic [DW-1:0] pin_oe
);
  genvar i;
  generate
    for (i = 0; i < DW; i++) begin : g_pin
      logic drv, dat;
      always_comb begin
        if (alt_en[i]) begin
          drv = alt_oe[i];
          dat = alt_o[i];
        end else begin
          drv = ~dir[i];
          dat = out_data[i];
        end
        pin_oe[i] = drv;
        pin_o[i]  = drv & dat;
      end

      // R5
      tristate_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!alt_en[i] && dir[i]) |-> (!pin_oe[i] && !pin_o[i]));

      // R6
      alt_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alt_en[i] |-> (pin_oe[i] == alt_oe[i]));
    end
  endgenerate
endmodule

// File: rtl/wgp_port.sv
module wgp_port
  import wgp_pkg::*;
#(
  parameter int DW        = 8,
  parameter int SYNC_LEN  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    bus_sel,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [DW-1:0] pin_i,
  output logic [DW-1:0] pin_o,
  output logic [DW-1:0] pin_oe,
  input  logic [DW-1:0] alt_o,
  input  logic [DW-1:0] alt_oe
);
  localparam int LAT = SYNC_LEN + 1;

  logic [1:0]    rst_sh_q;
  logic          rst_int_n;
  logic [DW-1:0] sync_q, in_q;
  logic [DW-1:0] dir_q, alt_q, out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  wgp_sync #(.W(DW), .STAGES(SYNC_LEN)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .d     (pin_i),
    .q     (sync_q)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) in_q <= '0;
    else            in_q <= sync_q;
  end

  wgp_regs #(.DW(DW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .sel     (regsel_e'(bus_sel)),
    .we      (bus_we),
    .wdata   (bus_wdata),
    .in_data (in_q),
    .rdata   (bus_rdata),
    .dir_q   (dir_q),
    .alt_q   (alt_q),
    .out_q   (out_q)
  );

  wgp_pinmux #(.DW(DW)) u_mux (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .dir      (dir_q),
    .alt_en   (alt_q),
    .out_data (out_q),
    .alt_o    (alt_o),
    .alt_oe   (alt_oe),
    .pin_o    (pin_o),
    .pin_oe   (pin_oe)
  );

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)      warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // R7
  in_latency_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (LAT == 3 && warm_q == 2'd3 && bus_sel == 2'd2) |-> (bus_rdata == $past(pin_i, 3)));
endmodule

// File: tb/wgp_port_test.sv
module wgp_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pin_i = 8'h00;
  logic [7:0] pin_o, pin_oe;
  logic [7:0] alt_o = 8'h00;
  logic [7:0] alt_oe = 8'h00;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wgp_port uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
    .pin_o(pin_o), .pin_oe(pin_oe), .alt_o(alt_o), .alt_oe(alt_oe)
  );

  // vector: [22:19] requirement, [18:17] sel, [16] we, [15:8] data, [7:0] expected read
  localparam int NV = 21;
  localparam logic [22:0] VEC [NV] = '{
    {4'd1,  2'd0, 1'b0, 8'h00, 8'h00},  // R1 pointer reset
    {4'd1,  2'd1, 1'b0, 8'h00, 8'h00},  // R1 window reset
    {4'd1,  2'd3, 1'b0, 8'h00, 8'h00},  // R1 output data reset
    {4'd10, 2'd0, 1'b1, 8'h01, 8'h00},  // R10 pointer to direction
    {4'd10, 2'd0, 1'b0, 8'h00, 8'h01},  // R10 pointer readback
    {4'd3,  2'd1, 1'b0, 8'h00, 8'hFF},  // R3 direction reset
    {4'd3,  2'd1, 1'b1, 8'hA5, 8'h00},  // R3 direction write
    {4'd2,  2'd1, 1'b0, 8'h00, 8'hA5},  // R2 window reaches direction
    {4'd10, 2'd3, 1'b1, 8'h3C, 8'h00},  // R10 output data write
    {4'd10, 2'd3, 1'b0, 8'h00, 8'h3C},  // R10 output data readback
    {4'd2,  2'd0, 1'b1, 8'h02, 8'h00},  // R2 pointer to alt enable
    {4'd2,  2'd1, 1'b0, 8'h00, 8'h00},  // R2 alt enable reset
    {4'd2,  2'd1, 1'b1, 8'h0F, 8'h00},  // R2 alt enable write
    {4'd2,  2'd1, 1'b0, 8'h00, 8'h0F},  // R2 alt enable readback
    {4'd9,  2'd0, 1'b1, 8'h07, 8'h00},  // R9 unimplemented pointer
    {4'd9,  2'd1, 1'b0, 8'h00, 8'h00},  // R9 reads zero
    {4'd9,  2'd1, 1'b1, 8'hFF, 8'h00},  // R9 write dropped
    {4'd9,  2'd0, 1'b1, 8'h01, 8'h00},  // R9 back to direction
    {4'd9,  2'd1, 1'b0, 8'h00, 8'hA5},  // R9 direction untouched
    {4'd9,  2'd0, 1'b1, 8'h02, 8'h00},  // R9 back to alt enable
    {4'd9,  2'd1, 1'b0, 8'h00, 8'h0F}   // R9 alt enable untouched
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    bus_sel = s;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check("R1 pin_oe in reset", pin_oe, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      if (VEC[k][16]) begin
        bus_write(VEC[k][18:17], VEC[k][15:8]);
      end else begin
        bus_read(VEC[k][18:17], rd);
        check($sformatf("R%0d vector %0d", VEC[k][22:19], k), rd, VEC[k][7:0]);
      end
    end

    // R4 R5: direction A5, output 3C, no alternate function
    bus_write(2'd0, 8'h02);
    bus_write(2'd1, 8'h00);
    @(negedge clk);
    check("R4 R5 pin_oe", pin_oe, 8'h5A);
    check("R4 R5 pin_o", pin_o, 8'h18);

    // R6: low nibble under alternate control, direction ignored there
    alt_o = 8'h55; alt_oe = 8'h33;
    bus_write(2'd1, 8'h0F);
    @(negedge clk);
    check("R6 pin_oe", pin_oe, 8'h53);
    check("R6 pin_o", pin_o, 8'h11);
    alt_oe = 8'h0C;
    #1 check("R6 pin_oe follows alt_oe", pin_oe, 8'h5C);

    // R7: input change visible after third edge only
    bus_sel = 2'd2;
    @(negedge clk);
    pin_i = 8'hC3;
    repeat (2) @(negedge clk);
    check("R7 not after two edges", bus_rdata, 8'h00);
    @(negedge clk);
    check("R7 after three edges", bus_rdata, 8'hC3);

    // R8: write to input data has no effect
    bus_write(2'd2, 8'h00);
    bus_read(2'd2, rd);
    check("R8 input register read-only", rd, 8'hC3);
    bus_read(2'd3, rd);
    check("R8 output data unchanged", rd, 8'h3C);

    // R1: reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 async pin_oe", pin_oe, 8'h00);
    @(negedge clk);
    bus_sel = 2'd0;
    #1 check("R1 pointer after reset", bus_rdata, 8'h00);
    bus_sel = 2'd3;
    #1 check("R1 output after reset", bus_rdata, 8'h00);
    bus_sel = 2'd2;
    #1 check("R1 input after reset", bus_rdata, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_write(2'd0, 8'h01);
    bus_read(2'd1, rd);
    check("R3 direction reset after rerun", rd, 8'hFF);

    finish_run();
  end
endmodule